// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block brings the supply of a removable card socket up and down in timed steps. On a power-up command it first forces both supply selects to 0 V and lets the rails drain, then selects 5 V on the main supply while the programming supply stays at 0 V. Once the rail has risen and settled, it pulses the card reset line and waits a short release time before it reports completion. A power-down command forces both supplies to 0 V and waits for the rails to fall before it reports completion.

The card-detect input is synchronised to the clock. A falling edge on it, meaning the card was pulled out, starts the power-down sequence at once, and it also cuts short a power-up that is under way. Each wait is a cycle count taken from a clock-frequency parameter. A time-scale divider can shorten every wait by the same factor so that the sequence runs quickly in simulation. While a sequence runs, `busy` stays high. A one-cycle `done` pulse closes every sequence.

Top module: `socket_power_seq`

## Requirements
- R1: After synchronous reset the block is idle with the socket off: `vcc_sel`=2'b00, `vpp_sel`=2'b00, `card_rst`=0, `busy`=0, `done`=0.
- R2: A power-up request accepted while idle raises `busy` at the accepting clock edge. It then holds `vcc_sel`=2'b00 (0 V) and `vpp_sel`=2'b00 (0 V) for a 20 ms hold followed by a 400 ms drain, 420 ms in total.
- R3: After the drain, `vcc_sel` is 2'b01 (5 V) for a 420 ms rise-and-settle wait. During this wait, and at every other time, `vpp_sel` stays 2'b00.
- R4: After the rise wait, `card_rst` is high for the reset time of 10 µs. Outside this pulse `card_rst` is low, and it is never high unless `vcc_sel` is 2'b01.
- R5: After the reset pulse, a 20 ms release wait passes and then `done` is high for exactly one cycle. In that same cycle `busy` falls and `vcc_sel` stays 2'b01.
- R6: A power-down request accepted while idle sets both selects to 2'b00 at the accepting edge. After 20 ms plus 300 ms, `done` pulses and `busy` falls.
- R7: Power-up and power-down requests that arrive while `busy` is high are ignored. They do not change the sequence.
- R8: `card_present` passes through a two-stage synchroniser. A falling edge on it changes the outputs on the third rising clock edge after the input falls. In the idle states and during power-up it starts the power-down of R6. During a power-down it is ignored, and a rising edge has no effect.
- R9: Each wait lasts exactly ceil(t × CLK_HZ / TIME_SCALE) cycles, and never less than one cycle.
- R10: A power-up request and a power-down request in the same idle cycle start the power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Power-up request, sampled when idle |
| dis_req | input | 1 | Power-down request, sampled when idle |
| card_present | input | 1 | Card-detect level, asynchronous, high while a card is seated |
| vcc_sel | output | 2 | Main supply select: 00 = 0 V, 01 = 5 V |
| vpp_sel | output | 2 | Programming supply select: 00 = 0 V |
| card_rst | output | 1 | Card reset, active high |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench compares every output in every cycle of complete power-up and power-down runs against phase lengths it computes from the ceiling formula. A phase that is one cycle too long or too short therefore shows up as a mismatch at that phase boundary, and a `done` pulse that is missing or two cycles long is caught as well. It also sends requests into a running sequence. A design that restarted or reversed on such a request would give a trace that no longer matches. Card removal is exercised during the rise wait, during the one-cycle reset pulse and while idle, which catches wrong synchroniser latency, a reset left high after the abort, and a design that never aborts. The bench also covers removal during a power-down, card insertion, and both requests in one cycle; a design would fail these if it restarted a shutdown, reacted to insertion, or gave priority to power-up.

// File: rtl/csps_pkg.sv
package csps_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_ZERO,
    ST_UP_FALL,
    ST_UP_RISE,
    ST_UP_RST,
    ST_UP_REL,
    ST_ON,
    ST_DN_ZERO,
    ST_DN_FALL
  } seq_state_t;

  localparam logic [1:0] VCC_0V = 2'b00;
  localparam logic [1:0] VCC_5V = 2'b01;
  localparam logic [1:0] VPP_0V = 2'b00;

  // ceil(amount / units_per_s * clk_hz / scale), at least one cycle
  function automatic longint unsigned cycles_for(
    input longint unsigned amount,
    input longint unsigned units_per_s,
    input longint unsigned clk_hz,
    input longint unsigned scale
  );
    longint unsigned num;
    longint unsigned den;
    longint unsigned q;
    num = amount * clk_hz;
    den = units_per_s * scale;
    q   = (num + den - 1) / den;
    return (q == 0) ? 64'd1 : q;
  endfunction

  function automatic longint unsigned max2(
    input longint unsigned a,
    input longint unsigned b
  );
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/csps_detect_sync.sv
module csps_detect_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign fall_pulse = prev_q & ~chain_q[STAGES-1];

  // R8: a removal pulse lasts a single cycle
  assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/csps_phase_timer.sv
module csps_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R9: a freshly loaded count steps down by one per cycle
  assert_timer_step_R9: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/csps_sequencer.sv
module csps_sequencer
  import csps_pkg::*;
#(
  parameter int          CW        = 8,
  parameter logic [CW-1:0] L_HOLD    = '0,
  parameter logic [CW-1:0] L_FALL_UP = '0,
  parameter logic [CW-1:0] L_RISE    = '0,
  parameter logic [CW-1:0] L_RST     = '0,
  parameter logic [CW-1:0] L_FALL_DN = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          removal,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic [1:0]    vcc_sel,
  output logic [1:0]    vpp_sel,
  output logic          card_rst,
  output logic          busy,
  output logic          done
);
  seq_state_t state_q, state_n;
  logic       finish;

  function automatic logic [CW-1:0] phase_len(input seq_state_t s);
    case (s)
      ST_UP_ZERO: return L_HOLD;
      ST_UP_FALL: return L_FALL_UP;
      ST_UP_RISE: return L_RISE;
      ST_UP_RST:  return L_RST;
      ST_UP_REL:  return L_HOLD;
      ST_DN_ZERO: return L_HOLD;
      ST_DN_FALL: return L_FALL_DN;
      default:    return '0;
    endcase
  endfunction

  always_comb begin
    state_n = state_q;
    finish  = 1'b0;
    case (state_q)
      ST_OFF, ST_ON: begin
        if (dis_req || removal) state_n = ST_DN_ZERO;
        else if (en_req)        state_n = ST_UP_ZERO;
      end
      ST_UP_ZERO: begin
        if (removal)          state_n = ST_DN_ZERO;
        else if (tmr_expired) state_n = ST_UP_FALL;
      end
      ST_UP_FALL: begin
        if (removal)          state_n = ST_DN_ZERO;
        else if (tmr_expired) state_n = ST_UP_RISE;
      end
      ST_UP_RISE: begin
        if (removal)          state_n = ST_DN_ZERO;
        else if (tmr_expired) state_n = ST_UP_RST;
      end
      ST_UP_RST: begin
        if (removal)          state_n = ST_DN_ZERO;
        else if (tmr_expired) state_n = ST_UP_REL;
      end
      ST_UP_REL: begin
        if (removal) state_n = ST_DN_ZERO;
        else if (tmr_expired) begin
          state_n = ST_ON;
          finish  = 1'b1;
        end
      end
      ST_DN_ZERO: begin
        if (tmr_expired) state_n = ST_DN_FALL;
      end
      ST_DN_FALL: begin
        if (tmr_expired) begin
          state_n = ST_OFF;
          finish  = 1'b1;
        end
      end
      default: state_n = ST_OFF;
    endcase
  end

  assign tmr_load = (state_n != state_q);
  assign tmr_val  = phase_len(state_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      vcc_sel  <= VCC_0V;
      vpp_sel  <= VPP_0V;
      card_rst <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      state_q  <= state_n;
      vcc_sel  <= (state_n inside {ST_UP_RISE, ST_UP_RST, ST_UP_REL, ST_ON})
                  ? VCC_5V : VCC_0V;
      vpp_sel  <= VPP_0V;
      card_rst <= (state_n == ST_UP_RST);
      busy     <= !(state_n inside {ST_OFF, ST_ON});
      done     <= finish;
    end
  end

  // R4: the card is only held in reset while powered
  assert_rst_needs_vcc_R4: assert property (@(posedge clk) disable iff (rst)
    card_rst |-> vcc_sel == VCC_5V);

  // R5: completion is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: busy is low in the completion cycle
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: every sequence opens with both supplies at 0 V
  assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (vcc_sel == VCC_0V && vpp_sel == VPP_0V));

  // R7: a power-up request mid-sequence does not restart it
  assert_busy_ignores_en_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && en_req && state_q != ST_UP_ZERO) |=> state_q != ST_UP_ZERO);

  // R8: removal during power-up enters the shutdown
  assert_removal_aborts_R8: assert property (@(posedge clk) disable iff (rst)
    (removal && state_q inside {ST_UP_ZERO, ST_UP_FALL, ST_UP_RISE, ST_UP_RST, ST_UP_REL})
    |=> (state_q == ST_DN_ZERO && vcc_sel == VCC_0V && !card_rst));

endmodule

// File: rtl/socket_power_seq.sv
module socket_power_seq
  import csps_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 200_000_000,
  parameter longint unsigned TIME_SCALE = 1,
  parameter int              SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_req,
  input  logic       dis_req,
  input  logic       card_present,
  output logic [1:0] vcc_sel,
  output logic [1:0] vpp_sel,
  output logic       card_rst,
  output logic       busy,
  output logic       done
);
  localparam longint unsigned N_HOLD    = cycles_for(20,  1000,      CLK_HZ, TIME_SCALE);
  localparam longint unsigned N_FALL_UP = cycles_for(400, 1000,      CLK_HZ, TIME_SCALE);
  localparam longint unsigned N_RISE    = cycles_for(420, 1000,      CLK_HZ, TIME_SCALE);
  localparam longint unsigned N_RST     = cycles_for(10,  1_000_000, CLK_HZ, TIME_SCALE);
  localparam longint unsigned N_FALL_DN = cycles_for(300, 1000,      CLK_HZ, TIME_SCALE);
  localparam longint unsigned N_MAX     =
    max2(max2(max2(N_HOLD, N_FALL_UP), max2(N_RISE, N_RST)), N_FALL_DN);
  localparam int              CW        = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  localparam logic [CW-1:0] L_HOLD    = CW'(N_HOLD - 1);
  localparam logic [CW-1:0] L_FALL_UP = CW'(N_FALL_UP - 1);
  localparam logic [CW-1:0] L_RISE    = CW'(N_RISE - 1);
  localparam logic [CW-1:0] L_RST     = CW'(N_RST - 1);
  localparam logic [CW-1:0] L_FALL_DN = CW'(N_FALL_DN - 1);

  logic          removal;
  logic          tmr_load;
  logic          tmr_expired;
  logic [CW-1:0] tmr_val;

  csps_detect_sync #(.STAGES(SYNC_STAGES)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .async_in   (card_present),
    .fall_pulse (removal)
  );

  csps_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  csps_sequencer #(
    .CW        (CW),
    .L_HOLD    (L_HOLD),
    .L_FALL_UP (L_FALL_UP),
    .L_RISE    (L_RISE),
    .L_RST     (L_RST),
    .L_FALL_DN (L_FALL_DN)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en_req      (en_req),
    .dis_req     (dis_req),
    .removal     (removal),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .vcc_sel     (vcc_sel),
    .vpp_sel     (vpp_sel),
    .card_rst    (card_rst),
    .busy        (busy),
    .done        (done)
  );

endmodule

// File: tb/socket_power_seq_bench.sv
`timescale 1ns/1ps
module socket_power_seq_bench;
  localparam longint unsigned CLK_HZ     = 1_000_000;
  localparam longint unsigned TIME_SCALE = 1000;

  function automatic int ceil_cycles(longint unsigned amt, longint unsigned per_s);
    longint unsigned n, d, q;
    n = amt * CLK_HZ;
    d = per_s * TIME_SCALE;
    q = (n + d - 1) / d;
    if (q == 0) q = 1;
    return int'(q);
  endfunction

  // R9: phase lengths from the ceiling formula
  int a_hold, b_drain, c_rise, r_rst, f_fall, s_up, s_dn;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0, card_present = 1'b1;
  logic [1:0] vcc_sel, vpp_sel;
  logic card_rst, busy, done;

  int n_total = 0;
  int n_bad   = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  socket_power_seq #(.CLK_HZ(CLK_HZ), .TIME_SCALE(TIME_SCALE)) u_socket_power_seq (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .card_present(card_present), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
    .card_rst(card_rst), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_total + 1, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected {vcc[1:0], vpp[1:0], rst, busy, done}
  task automatic chk(string req, logic [1:0] vcc_e, logic rst_e, logic busy_e, logic done_e);
    logic [6:0] act, exp_v;
    act   = {vcc_sel, vpp_sel, card_rst, busy, done};
    exp_v = {vcc_e, 2'b00, rst_e, busy_e, done_e};
    n_total++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b (vcc,vpp,rst,busy,done)", req, act, exp_v);
    end
  endtask

  task automatic up_expect(int i);
    if (i <= a_hold + b_drain)                       chk("R2", 2'b00, 0, 1, 0);
    else if (i <= a_hold + b_drain + c_rise)         chk("R3", 2'b01, 0, 1, 0);
    else if (i <= a_hold + b_drain + c_rise + r_rst) chk("R4", 2'b01, 1, 1, 0);
    else if (i <= s_up)                              chk("R5", 2'b01, 0, 1, 0);
    else if (i == s_up + 1)                          chk("R5", 2'b01, 0, 0, 1);
    else                                             chk("R5", 2'b01, 0, 0, 0);
  endtask

  task automatic down_expect(int j);
    if (j <= s_dn)          chk("R6", 2'b00, 0, 1, 0);
    else if (j == s_dn + 1) chk("R6", 2'b00, 0, 0, 1);
    else                    chk("R6", 2'b00, 0, 0, 0);
  endtask

  // power-up trace, optional request injected mid-sequence (R7)
  task automatic run_up(int inj_at, bit inj_en, bit inj_dis);
    en_req = 1'b1;
    step();
    en_req = 1'b0;
    for (int i = 1; i <= s_up + 2; i++) begin
      en_req = 1'b0;
      dis_req = 1'b0;
      up_expect(i);
      if (i == inj_at) begin
        en_req = inj_en;
        dis_req = inj_dis;
      end
      step();
    end
    en_req = 1'b0;
    dis_req = 1'b0;
  endtask

  // power-down trace from sample j=1 (already entered)
  task automatic down_trace(int inj_at, bit inj_en, int cd_at);
    for (int j = 1; j <= s_dn + 2; j++) begin
      en_req = 1'b0;
      down_expect(j);
      if (j == inj_at) en_req = inj_en;
      if (j == cd_at)  card_present = 1'b0;
      step();
    end
    en_req = 1'b0;
  endtask

  task automatic run_down(bit both, int inj_at, bit inj_en, int cd_at);
    dis_req = 1'b1;
    en_req  = both;
    step();
    dis_req = 1'b0;
    en_req  = 1'b0;
    down_trace(inj_at, inj_en, cd_at);
  endtask

  // power-up cut short by removal at sample m (R8)
  task automatic up_abort(int m);
    en_req = 1'b1;
    step();
    en_req = 1'b0;
    for (int i = 1; i <= m + 2; i++) begin
      up_expect(i);
      if (i == m) card_present = 1'b0;
      step();
    end
    down_trace(0, 1'b0, 0);
  endtask

  initial begin
    a_hold  = ceil_cycles(20, 1000);
    b_drain = ceil_cycles(400, 1000);
    c_rise  = ceil_cycles(420, 1000);
    r_rst   = ceil_cycles(10, 1_000_000);
    f_fall  = ceil_cycles(300, 1000);
    s_up    = a_hold + b_drain + c_rise + r_rst + a_hold;
    s_dn    = a_hold + f_fall;

    repeat (3) step();
    rst = 1'b0;
    // R1: idle after reset
    for (int k = 0; k < 5; k++) begin
      chk("R1", 2'b00, 0, 0, 0);
      step();
    end

    // R2 R3 R4 R5 R9: full power-up
    run_up(0, 1'b0, 1'b0);
    // R6: power-down from on
    run_down(1'b0, 0, 1'b0, 0);
    // R7: power-down request during power-up ignored
    run_up(50, 1'b0, 1'b1);
    run_up(0, 1'b0, 1'b0);
    // R7: power-up request during power-down ignored; R8: removal in shutdown ignored
    run_down(1'b0, 10, 1'b1, 30);
    // R8: insertion (rising edge) has no effect
    card_present = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chk("R8", 2'b00, 0, 0, 0);
      step();
    end
    // R10: both requests at once give power-down
    run_up(0, 1'b0, 1'b0);
    run_down(1'b1, 0, 1'b0, 0);
    // R8: removal during the rise wait
    up_abort(a_hold + b_drain + 10);
    card_present = 1'b1;
    repeat (4) step();
    // R8: removal landing on the reset pulse
    up_abort(a_hold + b_drain + c_rise - 1);
    card_present = 1'b1;
    repeat (4) step();
    // R8: removal while idle starts power-down after three edges
    card_present = 1'b0;
    step();
    chk("R8", 2'b00, 0, 0, 0);
    step();
    chk("R8", 2'b00, 0, 0, 0);
    step();
    down_trace(0, 1'b0, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule